// File: doc/BRIEF.md
# Divided Clock and SRAM Write-Strobe Generator

This block turns a fast oscillator clock into the main processor clock by dividing it by an integer `DIV_N`. It also emits a narrow strobe that is high for exactly one fast-clock period: the last fast-clock slot before each rising edge of the main clock. That strobe is gated with the decoded RAM write-enable level into an active-low write pulse for an asynchronous SRAM. The write happens only after the address and data have had `DIV_N-1` fast periods to settle, and it ends before the main-clock edge that lets the data bus change.

A mod-`DIV_N` phase counter tracks the position inside each main-clock cycle. Both clock outputs come straight from flip-flops, so no decode glitch can reach them. After reset the main clock stays low until the first counter wrap. The first main-clock cycle is therefore never a truncated one. The high part of the main clock lasts `HIGH_N` fast periods. That split is free, as long as the strobe slot falls in the low part.

Top module: `wsg_strobe_clkgen`

## Requirements
- R1: While `rst` is high at a rising `clk_fast` edge, the phase counter goes to 0, `mclk_o` and `strobe_o` go low and `wr_n_o` is high.
- R2: After the first wrap, `mclk_o` repeats with a period of `DIV_N` fast-clock periods. It is high for the `HIGH_N` fast periods that start at phase 0 and low for the rest. It rises only on the edge that follows a strobe slot.
- R3: After reset is released, `mclk_o` stays low until the phase counter first wraps from `DIV_N-1` to 0. The first main-clock rising edge then follows the first strobe slot.
- R4: `strobe_o` is high for exactly one fast-clock period per main-clock cycle, at phase `DIV_N-1`. It is never high together with `mclk_o`, and the counter is 0 in the period after it.
- R5: `wr_n_o` is the NAND of `strobe_o` and `ram_we_i`, so it is low only during a strobe slot with the write enable high.
- R6: A high `ram_we_i` outside the strobe slot has no effect: `wr_n_o` stays high.
- R7: A reset asserted in the middle of a main-clock cycle restarts the sequence as after power-up. R3 applies again after the release.
- R8: Parameters: `DIV_N` is at least 3, and `HIGH_N` lies in 1..`DIV_N-1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ram_we_i | input | 1 | Decoded RAM write-enable level |
| mclk_o | output | 1 | Main clock, fast clock divided by `DIV_N` |
| strobe_o | output | 1 | One-fast-period strobe before each main-clock rise |
| wr_n_o | output | 1 | Active-low SRAM write pulse |

## Verification
Two instances, divide-by-6 with a 3/3 split and divide-by-3 with a 1/2 split, are compared against a phase model every fast cycle. The write enable is driven held low, held high, alternating and pseudo-random. Held high separates a correct NAND from a pulse that leaks outside the strobe slot. Alternating and random patterns catch a gate that samples the enable at the wrong time. Resets at power-up and in mid-cycle separate a correct hold-low start from a truncated first main-clock high phase.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  // next phase of a mod-n counter
  function automatic int phase_step(int cur, int n);
    return (cur == n - 1) ? 0 : cur + 1;
  endfunction

  // main clock level for a given phase once the sequence is running
  function automatic logic mclk_level(int ph, int high_n, logic running);
    return running && (ph < high_n);
  endfunction

  // strobe occupies the final slot of each main-clock cycle
  function automatic logic strobe_level(int ph, int n);
    return ph == n - 1;
  endfunction

endpackage

// File: rtl/wsg_phase_counter.sv
module wsg_phase_counter #(
  parameter int DIV_N = 6,
  localparam int CW = (DIV_N > 1) ? $clog2(DIV_N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          run_nxt,
  output logic          wrap
);
  logic run_q;

  assign wrap    = ~rst && (int'(cnt_q) == DIV_N - 1);
  assign cnt_nxt = rst ? '0 : CW'(wsg_pkg::phase_step(int'(cnt_q), DIV_N));
  assign run_nxt = ~rst && (run_q || wrap);

  always_ff @(posedge clk) begin
    cnt_q <= cnt_nxt;
    run_q <= run_nxt;
  end
endmodule

// File: rtl/wsg_clk_regs.sv
module wsg_clk_regs #(
  parameter int DIV_N  = 6,
  parameter int HIGH_N = 3,
  localparam int CW = (DIV_N > 1) ? $clog2(DIV_N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          run_nxt,
  output logic          mclk_q,
  output logic          strobe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      mclk_q   <= wsg_pkg::mclk_level(int'(cnt_nxt), HIGH_N, run_nxt);
      strobe_q <= wsg_pkg::strobe_level(int'(cnt_nxt), DIV_N);
    end
  end
endmodule

// File: rtl/wsg_we_gate.sv
module wsg_we_gate (
  input  logic strobe,
  input  logic we_level,
  output logic wr_n
);
  assign wr_n = ~(strobe & we_level);
endmodule

// File: rtl/wsg_strobe_clkgen.sv
module wsg_strobe_clkgen #(
  parameter int DIV_N  = 6,
  parameter int HIGH_N = DIV_N / 2,
  localparam int CW = (DIV_N > 1) ? $clog2(DIV_N) : 1
) (
  input  logic clk_fast,
  input  logic rst,
  input  logic ram_we_i,
  output logic mclk_o,
  output logic strobe_o,
  output logic wr_n_o
);
  logic [CW-1:0] cnt_w;
  logic [CW-1:0] cnt_nxt_w;
  logic          run_nxt_w;
  logic          wrap_w;

  wsg_phase_counter #(.DIV_N(DIV_N)) u_cnt (
    .clk     (clk_fast),
    .rst     (rst),
    .cnt_q   (cnt_w),
    .cnt_nxt (cnt_nxt_w),
    .run_nxt (run_nxt_w),
    .wrap    (wrap_w)
  );

  wsg_clk_regs #(.DIV_N(DIV_N), .HIGH_N(HIGH_N)) u_regs (
    .clk      (clk_fast),
    .rst      (rst),
    .cnt_nxt  (cnt_nxt_w),
    .run_nxt  (run_nxt_w),
    .mclk_q   (mclk_o),
    .strobe_q (strobe_o)
  );

  wsg_we_gate u_gate (
    .strobe   (strobe_o),
    .we_level (ram_we_i),
    .wr_n     (wr_n_o)
  );
endmodule

// File: rtl/wsg_strobe_chk.sv
module wsg_strobe_chk #(
  parameter int DIV_N  = 6,
  parameter int HIGH_N = 3,
  localparam int CW = (DIV_N > 1) ? $clog2(DIV_N) : 1
) (
  input logic          clk_fast,
  input logic          rst,
  input logic          ram_we_i,
  input logic          mclk_o,
  input logic          strobe_o,
  input logic          wr_n_o,
  input logic [CW-1:0] cnt_w,
  input logic          wrap_w
);
  // R8
  initial param_range_chk: assert (DIV_N >= 3 && HIGH_N >= 1 && HIGH_N <= DIV_N - 1);

  // R1
  reset_state_chk: assert property (@(posedge clk_fast)
    rst |=> (!mclk_o && !strobe_o && cnt_w == '0));

  // R4
  strobe_single_chk: assert property (@(posedge clk_fast) disable iff (rst)
    strobe_o |=> !strobe_o);

  // R4
  strobe_then_zero_chk: assert property (@(posedge clk_fast) disable iff (rst)
    strobe_o |=> (cnt_w == '0));

  // R4
  strobe_in_low_chk: assert property (@(posedge clk_fast) disable iff (rst)
    strobe_o |-> !mclk_o);

  // R2
  mclk_rise_chk: assert property (@(posedge clk_fast) disable iff (rst)
    $rose(mclk_o) |-> $past(strobe_o));

  // R3
  wrap_from_top_chk: assert property (@(posedge clk_fast) disable iff (rst)
    wrap_w |-> strobe_o);

  // R5
  wr_gate_chk: assert property (@(posedge clk_fast) disable iff (rst)
    !wr_n_o |-> (strobe_o && ram_we_i));

  // R2
  cnt_range_chk: assert property (@(posedge clk_fast) disable iff (rst)
    int'(cnt_w) < DIV_N);
endmodule

bind wsg_strobe_clkgen wsg_strobe_chk #(.DIV_N(DIV_N), .HIGH_N(HIGH_N)) u_chk (
  .clk_fast (clk_fast),
  .rst      (rst),
  .ram_we_i (ram_we_i),
  .mclk_o   (mclk_o),
  .strobe_o (strobe_o),
  .wr_n_o   (wr_n_o),
  .cnt_w    (cnt_w),
  .wrap_w   (wrap_w)
);

// File: tb/wsg_strobe_clkgen_tb.sv
module wsg_strobe_clkgen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we  = 1'b0;
  logic mclk_a, strobe_a, wrn_a;
  logic mclk_b, strobe_b, wrn_b;
  int   pass_cnt = 0;
  int   fail_cnt = 0;
  bit   done = 0;

  // model state per instance: phase and running flag
  int   pa = 0, pb = 0;
  bit   ra = 0, rb = 0;
  logic [7:0] lfsr = 8'hA5;
  bit   after_mid_rst = 0;

  always #5 clk = ~clk;

  wsg_strobe_clkgen #(.DIV_N(6), .HIGH_N(3)) u_dut (
    .clk_fast(clk), .rst(rst), .ram_we_i(we),
    .mclk_o(mclk_a), .strobe_o(strobe_a), .wr_n_o(wrn_a));

  wsg_strobe_clkgen #(.DIV_N(3), .HIGH_N(1)) u_dut3 (
    .clk_fast(clk), .rst(rst), .ram_we_i(we),
    .mclk_o(mclk_b), .strobe_o(strobe_b), .wr_n_o(wrn_b));

  task automatic chk(string tag, logic act, logic exp);
    if (act === exp) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic check_dut(string nm, int n, int h, int p, bit r, bit in_rst,
                           logic mc, logic st, logic wn);
    logic e_m, e_s, e_w;
    e_m = r && (p < h);
    e_s = (p == n - 1);
    e_w = !(e_s && we);
    if (in_rst) begin
      chk({nm, " R1 mclk"}, mc, 1'b0);
      chk({nm, " R1 strobe"}, st, 1'b0);
      chk({nm, " R1 wr_n"}, wn, 1'b1);
    end else begin
      if (!r) chk({nm, after_mid_rst ? " R7 mclk" : " R3 mclk"}, mc, e_m);
      else    chk({nm, " R2 mclk"}, mc, e_m);
      chk({nm, " R4 strobe"}, st, e_s);
      if (!e_s && we) chk({nm, " R6 wr_n"}, wn, e_w);
      else            chk({nm, " R5 wr_n"}, wn, e_w);
    end
  endtask

  // apply inputs, let one rising edge pass, then compare at the falling edge
  task automatic cyc(bit r_v, logic we_v);
    rst = r_v;
    we  = we_v;
    @(negedge clk);
    if (r_v) begin pa = 0; ra = 0; pb = 0; rb = 0; end
    else begin
      pa = (pa + 1) % 6; if (pa == 0) ra = 1;
      pb = (pb + 1) % 3; if (pb == 0) rb = 1;
    end
    check_dut("div6", 6, 3, pa, ra, r_v, mclk_a, strobe_a, wrn_a);
    check_dut("div3", 3, 1, pb, rb, r_v, mclk_b, strobe_b, wrn_b);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1);          // R1 with enable high
    for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0);         // R2 R3 R4, enable low
    for (int i = 0; i < 30; i++) cyc(1'b0, 1'b1);         // R5 R6, enable held high
    for (int i = 0; i < 30; i++) cyc(1'b0, logic'(i % 2)); // alternating
    for (int i = 0; i < 60; i++) begin                      // pseudo-random
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cyc(1'b0, lfsr[0]);
    end
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0);          // land mid-cycle
    for (int i = 0; i < 2; i++) cyc(1'b1, 1'b1);          // R7 mid-run reset
    after_mid_rst = 1;
    for (int i = 0; i < 40; i++) cyc(1'b0, logic'((i % 3) == 2));
    done = 1;
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fail_cnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
      $finish;
    end
  end
endmodule